// File: doc/BRIEF.md
# Event-Triggered DMA Request Sequencer

This block is the control half of one audio DMA channel. Software programs a source pointer, a destination pointer and a block count, then arms the channel with a kick write that also names a trigger event. The channel waits for that event, checks that the requested route is supported, asks a data mover for one 128-byte burst per block, and finally asks for a completion notifier to be written. A seven-value status code shows its progress at all times, and a one-cycle completion pulse marks the end of every request.

The memory bus, the data path and the FIFOs sit outside. They appear only as two request/acknowledge pairs: one per burst and one for the notifier. A global clear input cancels any request in flight. A cancelled request still produces the completion pulse, so that downstream logic waiting for the channel sees it end as if it had finished.

Top module: `dma_evt_seq`

## Requirements
- R1: After reset the status is 0 (done), the kick readback is all zero, and burst_req, notify_req and done_pulse are low.
- R2: A kick write (select 0) with bit 0 set, made while the status is 0, 5 or 6, arms the channel. It captures the trigger code from bits [20:16] and moves the status to 1 (waiting for event). Kick readback bit 0 is 1 while the status is 1..4 and 0 otherwise, and bits [26:24] carry the status. A kick write with bit 0 clear does not arm the channel.
- R3: Trigger code 0 fires at once. Codes 1..14 and 19..28 fire when evt_vec bit [code] is 1. Any other code never fires, and other evt_vec bits have no effect.
- R4: When the trigger fires, status 2 (pending) is shown for exactly one cycle, followed by 3, 6 or 5.
- R5: The route is accepted only if source bits [1:0] equal 2 and destination bits [1:0] equal 1. Any other combination goes from pending to status 6 (error) with a completion pulse, and no burst is requested.
- R6: A size value N in bits [6:0] yields N+1 burst handshakes. For burst k, burst_src and burst_dst equal (start + k) shifted left by 7, where start is bits [31:7] of the respective register.
- R7: An acknowledged last burst moves the status to 4 and raises notify_req. notify_ack then moves the status to 0 and gives a completion pulse.
- R8: global_clear while the status is 1..4 moves it to 5 (clear) with a completion pulse. It wins over a burst_ack or notify_ack in the same cycle.
- R9: While the status is 1..4, writes to the kick, source, destination and size registers have no effect on their readback.
- R10: done_pulse is high for exactly one cycle, only in the first cycle that shows status 0, 5 or 6 after a busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 kick, 1 source, 2 destination, 3 size |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Readback select, same encoding as wr_sel |
| rd_data | output | 32 | Readback of the selected register |
| evt_vec | input | 32 | Hardware event lines, indexed by trigger code |
| global_clear | input | 1 | Cancel the request in flight |
| burst_req | output | 1 | Request one 128-byte burst |
| burst_src | output | 32 | Byte address of the burst source |
| burst_dst | output | 32 | Byte address of the burst destination |
| burst_ack | input | 1 | Data mover finished the current burst |
| notify_req | output | 1 | Request the completion notifier write |
| notify_ack | input | 1 | Notifier write finished |
| status | output | 3 | Progress code 0..6 |
| done_pulse | output | 1 | One-cycle completion marker |

## Verification
Two functions can land in the same cycle: the cancel path and the normal handshake path. The bench raises global_clear together with burst_ack on the only burst of a one-block request, and again together with notify_ack. Both times it expects status 5 and a single completion pulse, with no step to the notify state and no step to status 0. The bench also overlaps register writes with an active transfer and judges them by the readback after the write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_DONE   = 3'd0,
        ST_EVENT  = 3'd1,
        ST_PEND   = 3'd2,
        ST_XFER   = 3'd3,
        ST_NOTIFY = 3'd4,
        ST_CLEAR  = 3'd5,
        ST_ERROR  = 3'd6
    } seq_st_e;

    localparam logic [1:0] SEL_KICK = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_DST  = 2'd2;
    localparam logic [1:0] SEL_SIZE = 2'd3;

    localparam logic [1:0] TGT_SYSMEM = 2'd2;
    localparam logic [1:0] TGT_AFIFO  = 2'd1;

    // kick register field positions
    localparam int KICK_REQ_BIT = 0;
    localparam int KICK_EVT_LSB = 16;
    localparam int KICK_ST_LSB  = 24;

    // trigger code map
    localparam int LAST_BUF_EVT = 14;
    localparam int FIRST_CH_EVT = 19;
    localparam int NUM_CH_EVT   = 10;

endpackage

// File: rtl/dseq_evt_match.sv
module dseq_evt_match #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0]      code,
    input  logic [(1<<CODE_W)-1:0] evt_vec,
    output logic                   hit
);
    import dma_seq_pkg::*;

    localparam int NCODE = 1 << CODE_W;

    logic [NCODE-1:0] code_hit;

    for (genvar c = 0; c < NCODE; c++) begin : g_code
        if (c == 0) begin : g_now
            assign code_hit[c] = 1'b1;
        end else if ((c <= LAST_BUF_EVT) ||
                     ((c >= FIRST_CH_EVT) && (c < FIRST_CH_EVT + NUM_CH_EVT))) begin : g_line
            assign code_hit[c] = evt_vec[c];
        end else begin : g_never
            logic unused_line;
            assign unused_line = evt_vec[c];
            assign code_hit[c] = 1'b0;
        end
    end

    assign hit = code_hit[code];

endmodule

// File: rtl/dseq_cfg_regs.sv
module dseq_cfg_regs #(
    parameter int DATA_W  = 32,
    parameter int ALIGN_W = 7,
    parameter int SIZE_W  = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        busy,
    output logic [DATA_W-ALIGN_W-1:0]   src_start,
    output logic [1:0]                  src_tgt,
    output logic [DATA_W-ALIGN_W-1:0]   dst_start,
    output logic [1:0]                  dst_tgt,
    output logic [SIZE_W-1:0]           size
);
    import dma_seq_pkg::*;

    localparam int START_W = DATA_W - ALIGN_W;

    typedef struct packed {
        logic [START_W-1:0] s_start;
        logic [1:0]         s_tgt;
        logic [START_W-1:0] d_start;
        logic [1:0]         d_tgt;
        logic [SIZE_W-1:0]  sz;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !busy) begin
            case (wr_sel)
                SEL_SRC: begin
                    cfg_d.s_start = wr_data[DATA_W-1:ALIGN_W];
                    cfg_d.s_tgt   = wr_data[1:0];
                end
                SEL_DST: begin
                    cfg_d.d_start = wr_data[DATA_W-1:ALIGN_W];
                    cfg_d.d_tgt   = wr_data[1:0];
                end
                SEL_SIZE: cfg_d.sz = wr_data[SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src_start = cfg_q.s_start;
    assign src_tgt   = cfg_q.s_tgt;
    assign dst_start = cfg_q.d_start;
    assign dst_tgt   = cfg_q.d_tgt;
    assign size      = cfg_q.sz;

    // R9: a write while busy leaves the size register untouched
    assert_size_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_sel == SEL_SIZE) |=> $stable(size));

endmodule

// File: rtl/dseq_blk_gen.sv
module dseq_blk_gen #(
    parameter int SIZE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] blk,
    output logic              last
);
    logic [SIZE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)      cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign blk  = cnt_q;
    assign last = (cnt_q == size);

    // R6: stepping never runs past the programmed block count
    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> (cnt_q != size));

endmodule

// File: rtl/dma_evt_seq.sv
module dma_evt_seq #(
    parameter int DATA_W  = 32,
    parameter int ALIGN_W = 7,
    parameter int SIZE_W  = 7,
    parameter int CODE_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [1:0]             rd_sel,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [(1<<CODE_W)-1:0] evt_vec,
    input  logic                   global_clear,
    output logic                   burst_req,
    output logic [DATA_W-1:0]      burst_src,
    output logic [DATA_W-1:0]      burst_dst,
    input  logic                   burst_ack,
    output logic                   notify_req,
    input  logic                   notify_ack,
    output logic [2:0]             status,
    output logic                   done_pulse
);
    import dma_seq_pkg::*;

    localparam int START_W = DATA_W - ALIGN_W;

    typedef struct packed {
        seq_st_e           st;
        logic [CODE_W-1:0] evt;
        logic              done;
    } fsm_s;

    fsm_s f_d, f_q;

    logic                busy;
    logic                kick_arm;
    logic                hit;
    logic                route_ok;
    logic                blk_load;
    logic                blk_step;
    logic                blk_last;
    logic [SIZE_W-1:0]   blk;
    logic [START_W-1:0]  src_start, dst_start;
    logic [1:0]          src_tgt, dst_tgt;
    logic [SIZE_W-1:0]   size;

    assign busy = (f_q.st == ST_EVENT) || (f_q.st == ST_PEND) ||
                  (f_q.st == ST_XFER)  || (f_q.st == ST_NOTIFY);

    assign kick_arm = wr_en && (wr_sel == SEL_KICK) && wr_data[KICK_REQ_BIT];
    assign route_ok = (src_tgt == TGT_SYSMEM) && (dst_tgt == TGT_AFIFO);

    dseq_cfg_regs #(
        .DATA_W (DATA_W),
        .ALIGN_W(ALIGN_W),
        .SIZE_W (SIZE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .busy     (busy),
        .src_start(src_start),
        .src_tgt  (src_tgt),
        .dst_start(dst_start),
        .dst_tgt  (dst_tgt),
        .size     (size)
    );

    dseq_evt_match #(.CODE_W(CODE_W)) u_match (
        .code   (f_q.evt),
        .evt_vec(evt_vec),
        .hit    (hit)
    );

    dseq_blk_gen #(.SIZE_W(SIZE_W)) u_blk (
        .clk  (clk),
        .rst_n(rst_n),
        .load (blk_load),
        .step (blk_step),
        .size (size),
        .blk  (blk),
        .last (blk_last)
    );

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        blk_load = 1'b0;
        blk_step = 1'b0;
        if (busy && global_clear) begin
            f_d.st   = ST_CLEAR;
            f_d.done = 1'b1;
        end else begin
            case (f_q.st)
                ST_EVENT: if (hit) f_d.st = ST_PEND;
                ST_PEND: begin
                    if (route_ok) begin
                        f_d.st   = ST_XFER;
                        blk_load = 1'b1;
                    end else begin
                        f_d.st   = ST_ERROR;
                        f_d.done = 1'b1;
                    end
                end
                ST_XFER: begin
                    if (burst_ack) begin
                        if (blk_last) f_d.st = ST_NOTIFY;
                        else          blk_step = 1'b1;
                    end
                end
                ST_NOTIFY: begin
                    if (notify_ack) begin
                        f_d.st   = ST_DONE;
                        f_d.done = 1'b1;
                    end
                end
                default: begin
                    if (kick_arm) begin
                        f_d.st  = ST_EVENT;
                        f_d.evt = wr_data[KICK_EVT_LSB +: CODE_W];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_DONE, evt: '0, done: 1'b0};
        else        f_q <= f_d;
    end

    logic [START_W-1:0] src_cur, dst_cur;
    assign src_cur = src_start + START_W'(blk);
    assign dst_cur = dst_start + START_W'(blk);

    assign burst_req  = (f_q.st == ST_XFER);
    assign notify_req = (f_q.st == ST_NOTIFY);
    assign burst_src  = {src_cur, {ALIGN_W{1'b0}}};
    assign burst_dst  = {dst_cur, {ALIGN_W{1'b0}}};
    assign status     = f_q.st;
    assign done_pulse = f_q.done;

    logic [DATA_W-1:0] kick_rd;
    always_comb begin
        kick_rd = '0;
        kick_rd[KICK_REQ_BIT]           = busy;
        kick_rd[KICK_EVT_LSB +: CODE_W] = f_q.evt;
        kick_rd[KICK_ST_LSB +: 3]       = f_q.st;
    end

    always_comb begin
        case (rd_sel)
            SEL_SRC:  rd_data = {src_start, {(ALIGN_W-2){1'b0}}, src_tgt};
            SEL_DST:  rd_data = {dst_start, {(ALIGN_W-2){1'b0}}, dst_tgt};
            SEL_SIZE: rd_data = DATA_W'(size);
            default:  rd_data = kick_rd;
        endcase
    end

    // R10: the completion pulse only accompanies a terminal status
    assert_pulse_terminal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (status == ST_DONE || status == ST_CLEAR || status == ST_ERROR));

    // R8: a clear during a busy state lands in CLEAR with a pulse
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && global_clear) |=> (status == ST_CLEAR && done_pulse));

    // R4: pending lasts one cycle
    assert_pend_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_PEND) |=> (status == ST_XFER || status == ST_ERROR || status == ST_CLEAR));

    // R5: the error state is entered only from pending
    assert_err_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_ERROR && $past(status) != ST_ERROR) |-> ($past(status) == ST_PEND));

    // R9: source pointer frozen against writes while busy
    assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_sel == SEL_SRC) |=> $stable(src_start));

    // R7: notify requested only after bursts finish
    assert_notify_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(notify_req) |-> ($past(burst_req) && $past(burst_ack)));

endmodule

// File: tb/dma_evt_seq_tb.sv
module dma_evt_seq_tb;
    import dma_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [31:0] evt_vec = '0;
    logic        global_clear = 1'b0;
    logic        burst_req;
    logic [31:0] burst_src, burst_dst;
    logic        burst_ack = 1'b0;
    logic        notify_req;
    logic        notify_ack = 1'b0;
    logic [2:0]  status;
    logic        done_pulse;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [24:0] SBASE = 25'h0123456;
    localparam logic [24:0] DBASE = 25'h0000AB0;

    always #10 clk = ~clk;

    dma_evt_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .evt_vec     (evt_vec),
        .global_clear(global_clear),
        .burst_req   (burst_req),
        .burst_src   (burst_src),
        .burst_dst   (burst_dst),
        .burst_ack   (burst_ack),
        .notify_req  (notify_req),
        .notify_ack  (notify_ack),
        .status      (status),
        .done_pulse  (done_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel; #1; val = rd_data;
    endtask

    function automatic logic [31:0] kick_word(input int code);
        return (32'(code) << 16) | 32'd1;
    endfunction

    task automatic setup(input logic [1:0] stgt, input logic [1:0] dtgt, input logic [6:0] n);
        wr(SEL_SRC, {SBASE, 5'b0, stgt});
        wr(SEL_DST, {DBASE, 5'b0, dtgt});
        wr(SEL_SIZE, {25'b0, n});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(SEL_KICK, v);
        chk("R1 kick readback", v, 32'h0);
        chk("R1 status", 32'(status), 32'd0);
        chk("R1 handshakes idle", {29'b0, burst_req, notify_req, done_pulse}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        setup(TGT_SYSMEM, TGT_AFIFO, 7'd2);
        wr(SEL_KICK, kick_word(0));
        chk("R2 armed status", 32'(status), 32'd1);
        rd(SEL_KICK, v);
        chk("R2 request bit busy", 32'(v[0]), 32'd1);
        chk("R2 status field", 32'(v[26:24]), 32'd1);
        tick();
        chk("R3 code0 immediate / R4 pending", 32'(status), 32'd2);
        tick();
        chk("R4 pending one cycle", 32'(status), 32'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R6 burst_req", 32'(burst_req), 32'd1);
            chk("R6 src addr", burst_src, {SBASE + 25'(k), 7'b0});
            chk("R6 dst addr", burst_dst, {DBASE + 25'(k), 7'b0});
            if (k == 1) begin
                wr(SEL_SRC, 32'hFFFF_FF82);
                rd(SEL_SRC, v);
                chk("R9 src ignored while busy", v, {SBASE, 5'b0, 2'b10});
                chk("R6 idle while no ack", 32'(status), 32'd3);
            end
            burst_ack = 1'b1;
            tick();
            burst_ack = 1'b0;
        end
        chk("R7 notify state", 32'(status), 32'd4);
        chk("R7 notify_req", {30'b0, burst_req, notify_req}, 32'h1);
        tick();
        chk("R7 waits for notify_ack", 32'(status), 32'd4);
        notify_ack = 1'b1;
        tick();
        notify_ack = 1'b0;
        chk("R7 done status", 32'(status), 32'd0);
        chk("R7 done pulse", 32'(done_pulse), 32'd1);
        rd(SEL_KICK, v);
        chk("R2 request bit idle after done", 32'(v[0]), 32'd0);
        tick();
        chk("R10 pulse one cycle", 32'(done_pulse), 32'd0);
    endtask

    task automatic t_event_wait();
        setup(TGT_SYSMEM, TGT_AFIFO, 7'd0);
        wr(SEL_KICK, kick_word(5));
        evt_vec = 32'h0000_0040;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 waits for selected line", 32'(status), 32'd1);
        end
        evt_vec[5] = 1'b1;
        tick();
        chk("R3 line 5 fires", 32'(status), 32'd2);
        evt_vec = '0;
        tick();
        chk("R4 into transfer", 32'(status), 32'd3);
        global_clear = 1'b1;
        burst_ack = 1'b1;
        tick();
        global_clear = 1'b0;
        burst_ack = 1'b0;
        chk("R8 clear beats burst_ack", 32'(status), 32'd5);
        chk("R8 clear pulse", 32'(done_pulse), 32'd1);
        chk("R8 no burst after clear", {30'b0, burst_req, notify_req}, 32'h0);
        tick();
        chk("R10 clear pulse one cycle", 32'(done_pulse), 32'd0);
    endtask

    task automatic t_codes();
        evt_vec = 32'h1000_0000;
        wr(SEL_KICK, kick_word(28));
        tick();
        chk("R3 channel-9 code fires", 32'(status), 32'd2);
        evt_vec = '0;
        global_clear = 1'b1;
        tick();
        global_clear = 1'b0;
        chk("R8 clear from pending", 32'(status), 32'd5);
        evt_vec = 32'hFFFF_FFFF;
        wr(SEL_KICK, kick_word(16));
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 unused code never fires", 32'(status), 32'd1);
        end
        global_clear = 1'b1;
        tick();
        global_clear = 1'b0;
        evt_vec = '0;
        chk("R8 clear from event wait", 32'(status), 32'd5);
    endtask

    task automatic t_error();
        logic [31:0] v;
        setup(TGT_SYSMEM, 2'b10, 7'd0);
        wr(SEL_KICK, kick_word(0));
        tick();
        chk("R5 pending before check", 32'(status), 32'd2);
        tick();
        chk("R5 bad route error", 32'(status), 32'd6);
        chk("R5 error pulse", 32'(done_pulse), 32'd1);
        chk("R5 no burst", 32'(burst_req), 32'd0);
        rd(SEL_DST, v);
        chk("R5 dst readback", v, {DBASE, 5'b0, 2'b10});
    endtask

    task automatic t_notify_clear();
        setup(TGT_SYSMEM, TGT_AFIFO, 7'd0);
        wr(SEL_KICK, kick_word(0));
        tick();
        tick();
        burst_ack = 1'b1;
        tick();
        burst_ack = 1'b0;
        chk("R6 one block for size 0", 32'(status), 32'd4);
        notify_ack = 1'b1;
        global_clear = 1'b1;
        tick();
        notify_ack = 1'b0;
        global_clear = 1'b0;
        chk("R8 clear beats notify_ack", 32'(status), 32'd5);
        chk("R8 single pulse", 32'(done_pulse), 32'd1);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(SEL_KICK, 32'h0003_0000);
        chk("R2 kick without bit0 ignored", 32'(status), 32'd5);
        wr(SEL_KICK, kick_word(16));
        wr(SEL_KICK, kick_word(3));
        rd(SEL_KICK, v);
        chk("R9 kick ignored while busy", 32'(v[20:16]), 32'd16);
        wr(SEL_SIZE, 32'h0000_0055);
        rd(SEL_SIZE, v);
        chk("R9 size ignored while busy", v, 32'h0);
        wr(SEL_DST, 32'h1234_5681);
        rd(SEL_DST, v);
        chk("R9 dst ignored while busy", v, {DBASE, 5'b0, 2'b01});
        global_clear = 1'b1;
        tick();
        global_clear = 1'b0;
        wr(SEL_SIZE, 32'h0000_0055);
        rd(SEL_SIZE, v);
        chk("R9 size accepted when idle", v, 32'h55);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_event_wait();
        t_codes();
        t_error();
        t_notify_clear();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule